// File: doc/BRIEF.md
# DMA Channel Run Control

This block holds the run control of a small DMA engine with two channels. Each channel has one 8-bit register that holds two flags: an enable flag, which gates whether the channel accepts triggers at all, and a start flag. Software sets the start flag to arm the channel and reads it back as a busy indication. The CPU writes the register either as a whole byte or one bit at a time. A read port returns the register of the addressed channel.

When a channel is enabled and armed, a software trigger or the selected hardware trigger launches a transfer request toward the transfer engine over a valid/ready handshake. The engine reports completion with a one-cycle pulse. Completion clears the start flag in hardware and raises a one-cycle channel interrupt. Clearing the start flag from software while a request is pending or a transfer is running aborts it, and the engine is told through a one-cycle abort pulse. The enable flag is write-protected while the start flag is set, so the channel cannot be disabled in the middle of a transfer.

Once `req_valid` for a channel has risen, it stays high and the channel stays in the request phase until `req_ready` is sampled high on a clock edge. A software abort is the only thing that withdraws a request. The engine may hold `req_ready` low for any number of cycles. Its `xfer_done` pulse is only honoured after the request has been accepted.

Top module: `dma_run_ctl_top`

## Requirements
- R1: After reset both registers read 0x00, and `req_valid`, `xfer_abort` and `ch_irq` are all low.
- R2: A read returns the enable flag in bit 7 and the start flag in bit 0. Bits 6..1 always read 0, even after 1s are written to them. `rd_addr`/`wr_addr` value n selects channel n.
- R3: While the start flag is 1, any write (byte or bit) leaves the enable flag unchanged. The start-flag part of the same byte write still takes effect.
- R4: A bit write changes only bit `bit_wr_idx` (7 = enable, 0 = start). Indices 1..6 have no effect. If a byte write and a bit write hit the same channel in one cycle, the byte write wins.
- R5: A trigger (`sw_trig` or `hw_trig`) sampled while the channel is waiting with enable = 1 and start = 1 makes `req_valid` high from the next cycle. A trigger is ignored while enable = 0 or start = 0, and the start flag keeps its value.
- R6: `req_valid` stays high until `req_ready` is sampled high. It is low from the cycle after that edge.
- R7: An `xfer_done` pulse while a transfer is running clears the start flag at that edge, and `ch_irq` is high for exactly the following cycle. `xfer_done` at any other time is ignored.
- R8: Writing start = 0 while a request is pending or a transfer is running raises `xfer_abort` for the single following cycle. `req_valid` is low in that cycle, no interrupt is raised, and a later `xfer_done` is ignored.
- R9: If `xfer_done` and a write of start = 1 to a running channel fall in the same cycle, the start flag ends at 0 and the interrupt fires.
- R10: The two channels are independent. Writes, triggers and handshakes of one channel do not change the other channel's register or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 1 | Channel selected by the byte write |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_wr_addr | input | 1 | Channel selected by the bit write |
| bit_wr_idx | input | 3 | Bit index of the bit write |
| bit_wr_val | input | 1 | Value written to the indexed bit |
| rd_addr | input | 1 | Channel selected for readback |
| rd_data | output | 8 | Register contents of the selected channel |
| sw_trig | input | 2 | Software trigger, one bit per channel |
| hw_trig | input | 2 | Selected hardware start trigger, one bit per channel |
| req_valid | output | 2 | Transfer request to the engine, per channel |
| req_ready | input | 2 | Engine accepts the request, per channel |
| xfer_done | input | 2 | Completion pulse from the engine, per channel |
| xfer_abort | output | 2 | One-cycle abort notice to the engine, per channel |
| ch_irq | output | 2 | One-cycle completion interrupt, per channel |

## Verification
Every flag, request, abort and interrupt result is due in the first cycle after the clock edge that samples its cause. The register readback is combinational from the flags, so it shows a write one edge after the write strobe. The bench drives every input on the falling edge and holds it through exactly one rising edge. It checks at the next falling edge, which is the cycle the result is due. Where a result must last only one cycle (`ch_irq`, `xfer_abort`), or must persist under back-pressure (`req_valid`), the bench checks again one falling edge later.

// File: rtl/dma_run_pkg.sv
package dma_run_pkg;
  localparam int REG_W  = 8;
  localparam int EN_BIT = 7;
  localparam int ST_BIT = 0;
  localparam int IDX_W  = $clog2(REG_W);

  typedef enum logic [1:0] {
    SEQ_WAIT = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_BUSY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dma_run_wrport.sv
module dma_run_wrport
  import dma_run_pkg::*;
(
  input  logic             byte_hit,
  input  logic             byte_en_bit,
  input  logic             byte_st_bit,
  input  logic             bit_hit,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  input  logic             cur_en,
  input  logic             cur_st,
  output logic             wr_hit,
  output logic             new_en,
  output logic             new_st
);
  // A byte write overrides a bit write to the same channel in the same cycle.
  always_comb begin
    wr_hit = byte_hit | bit_hit;
    new_en = cur_en;
    new_st = cur_st;
    if (byte_hit) begin
      new_en = byte_en_bit;
      new_st = byte_st_bit;
    end else if (bit_hit) begin
      if (bit_idx == IDX_W'(EN_BIT)) new_en = bit_val;
      if (bit_idx == IDX_W'(ST_BIT)) new_st = bit_val;
    end
  end
endmodule

// File: rtl/dma_run_flags.sv
module dma_run_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic new_en,
  input  logic new_st,
  input  logic done_ok,
  output logic en,
  output logic st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      st <= 1'b0;
    end else begin
      // enable may only move while no transfer is pending
      if (wr_hit && !st) en <= new_en;
      // completion outranks any software write of the start flag
      if (done_ok)     st <= 1'b0;
      else if (wr_hit) st <= new_st;
    end
  end

  a_r3_en_locked: assert property (@(posedge clk) disable iff (!rst_n)
    st |=> $stable(en));
  a_r9_done_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !st);
endmodule

// File: rtl/dma_run_seq.sv
module dma_run_seq
  import dma_run_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic st,
  input  logic trig,
  input  logic req_ready,
  input  logic xfer_done,
  output logic req_valid,
  output logic xfer_abort,
  output logic done_ok,
  output logic irq
);
  seq_state_e state_q, state_d;
  logic       running;
  logic       trig_ok;

  assign running    = (state_q != SEQ_WAIT);
  assign trig_ok    = en && st && (state_q == SEQ_WAIT) && trig;
  assign xfer_abort = running && !st;
  assign req_valid  = (state_q == SEQ_REQ) && st;
  assign done_ok    = (state_q == SEQ_BUSY) && st && xfer_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_WAIT: if (trig_ok) state_d = SEQ_REQ;
      SEQ_REQ: begin
        if (!st)           state_d = SEQ_WAIT;
        else if (req_ready) state_d = SEQ_BUSY;
      end
      SEQ_BUSY: begin
        if (!st || xfer_done) state_d = SEQ_WAIT;
      end
      default: state_d = SEQ_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_WAIT;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      irq     <= done_ok;
    end
  end

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid || xfer_abort));
  a_r5_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> en);
  a_r8_abort_without_irq: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> !irq);
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/dma_run_ctl_top.sv
module dma_run_ctl_top
  import dma_run_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              bit_wr_en,
  input  logic [AW-1:0]     bit_wr_addr,
  input  logic [IDX_W-1:0]  bit_wr_idx,
  input  logic              bit_wr_val,
  input  logic [AW-1:0]     rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [NUM_CH-1:0] sw_trig,
  input  logic [NUM_CH-1:0] hw_trig,
  output logic [NUM_CH-1:0] req_valid,
  input  logic [NUM_CH-1:0] req_ready,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic [NUM_CH-1:0] xfer_abort,
  output logic [NUM_CH-1:0] ch_irq
);
  logic [NUM_CH-1:0] en, st, wr_hit, new_en, new_st, done_ok;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_run_wrport u_wr (
      .byte_hit    (wr_en && (wr_addr == AW'(c))),
      .byte_en_bit (wr_data[EN_BIT]),
      .byte_st_bit (wr_data[ST_BIT]),
      .bit_hit     (bit_wr_en && (bit_wr_addr == AW'(c))),
      .bit_idx     (bit_wr_idx),
      .bit_val     (bit_wr_val),
      .cur_en      (en[c]),
      .cur_st      (st[c]),
      .wr_hit      (wr_hit[c]),
      .new_en      (new_en[c]),
      .new_st      (new_st[c])
    );

    dma_run_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit[c]),
      .new_en  (new_en[c]),
      .new_st  (new_st[c]),
      .done_ok (done_ok[c]),
      .en      (en[c]),
      .st      (st[c])
    );

    dma_run_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en[c]),
      .st         (st[c]),
      .trig       (sw_trig[c] | hw_trig[c]),
      .req_ready  (req_ready[c]),
      .xfer_done  (xfer_done[c]),
      .req_valid  (req_valid[c]),
      .xfer_abort (xfer_abort[c]),
      .done_ok    (done_ok[c]),
      .irq        (ch_irq[c])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == AW'(c)) begin
        rd_data[EN_BIT] = en[c];
        rd_data[ST_BIT] = st[c];
      end
    end
  end

  a_r10_irq_abort_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq & xfer_abort) == '0);
endmodule

// File: tb/test_dma_run_ctl_top.sv
`timescale 1ns/100ps
module test_dma_run_ctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, bit_wr_en = 0, bit_wr_val = 0;
  logic [0:0] wr_addr = 0, bit_wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] bit_wr_idx = 0;
  logic [7:0] rd_data;
  logic [1:0] sw_trig = 0, hw_trig = 0, req_ready = 0, xfer_done = 0;
  logic [1:0] req_valid, xfer_abort, ch_irq;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_run_ctl_top i_dma_run_ctl_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bit_wr_en(bit_wr_en), .bit_wr_addr(bit_wr_addr), .bit_wr_idx(bit_wr_idx),
    .bit_wr_val(bit_wr_val), .rd_addr(rd_addr), .rd_data(rd_data),
    .sw_trig(sw_trig), .hw_trig(hw_trig), .req_valid(req_valid),
    .req_ready(req_ready), .xfer_done(xfer_done), .xfer_abort(xfer_abort),
    .ch_irq(ch_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // advance one rising edge; inputs set before the call are held across it
  task automatic step();
    @(negedge clk);
    wr_en = 0; bit_wr_en = 0; sw_trig = 0; hw_trig = 0;
    req_ready = 0; xfer_done = 0;
  endtask

  task automatic wbyte(input int ch, input logic [7:0] d);
    wr_en = 1; wr_addr = ch[0]; wr_data = d; step();
  endtask

  task automatic wbit(input int ch, input int idx, input logic v);
    bit_wr_en = 1; bit_wr_addr = ch[0]; bit_wr_idx = idx[2:0]; bit_wr_val = v; step();
  endtask

  task automatic rchk(input string req, input int ch, input int exp);
    rd_addr = ch[0]; #0.1;
    chk(req, int'(rd_data), exp);
  endtask

  // bring channel ch to the running state: armed, triggered, accepted
  task automatic to_busy(input int ch);
    wbyte(ch, 8'h80); wbyte(ch, 8'h81);
    sw_trig[ch] = 1'b1; step();
    req_ready[ch] = 1'b1; step();
  endtask

  task automatic t_reset();
    rchk("R1 ch0 reset", 0, 'h00);
    rchk("R1 ch1 reset", 1, 'h00);
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 abort", int'(xfer_abort), 0);
    chk("R1 irq", int'(ch_irq), 0);
  endtask

  task automatic t_readback();
    wbyte(0, 8'hFE);
    rchk("R2 reserved bits read 0, enable set", 0, 'h80);
    rchk("R10 ch1 untouched by ch0 write", 1, 'h00);
    wbyte(1, 8'h7E);
    rchk("R2 reserved bits on ch1", 1, 'h00);
    wbyte(0, 8'h00);
    rchk("R2 cleared", 0, 'h00);
  endtask

  task automatic t_protect();
    wbyte(0, 8'h01);
    rchk("R3 start set while disabled", 0, 'h01);
    wbyte(0, 8'h81);
    rchk("R3 enable write ignored while start=1", 0, 'h01);
    wbit(0, 7, 1'b1);
    rchk("R3 bit write of enable ignored while start=1", 0, 'h01);
    sw_trig[0] = 1; step();
    chk("R5 trigger ignored while disabled", int'(req_valid), 0);
    rchk("R5 start kept while disabled", 0, 'h01);
    wbyte(0, 8'h00); wbyte(0, 8'h80); wbyte(0, 8'h81);
    rchk("R3 arm enabled channel", 0, 'h81);
    wbyte(0, 8'h01);
    rchk("R3 enable clear ignored while start=1", 0, 'h81);
    step(); // waiting channel: settle before the abort-free clear
    wbyte(0, 8'h80);
    chk("R8 no abort when nothing running", int'(xfer_abort), 0);
    rchk("R3 start cleared, enable kept", 0, 'h80);
    wbyte(0, 8'h00);
  endtask

  task automatic t_bitwrite();
    wbit(0, 7, 1'b1);
    rchk("R4 bit 7 sets enable", 0, 'h80);
    wbit(0, 3, 1'b1);
    rchk("R4 bit 3 has no effect", 0, 'h80);
    wbit(0, 0, 1'b1);
    rchk("R4 bit 0 sets start", 0, 'h81);
    wbit(0, 0, 1'b0);
    rchk("R4 bit 0 clears start", 0, 'h80);
    wr_en = 1; wr_addr = 0; wr_data = 8'h00;
    bit_wr_en = 1; bit_wr_addr = 0; bit_wr_idx = 0; bit_wr_val = 1; step();
    rchk("R4 byte write wins over bit write", 0, 'h00);
  endtask

  task automatic t_transfer();
    wbyte(0, 8'h80);
    sw_trig[0] = 1; step();
    chk("R5 trigger ignored while start=0", int'(req_valid), 0);
    wbyte(0, 8'h81);
    hw_trig[0] = 1; step();
    chk("R5 hw trigger raises request", int'(req_valid), 'b01);
    step();
    chk("R6 request held without ready", int'(req_valid), 'b01);
    step();
    chk("R6 request still held", int'(req_valid), 'b01);
    req_ready[0] = 1; step();
    chk("R6 request drops after ready", int'(req_valid), 0);
    rchk("R6 start still set while running", 0, 'h81);
    xfer_done[0] = 1; step();
    rchk("R7 done clears start", 0, 'h80);
    chk("R7 irq after done", int'(ch_irq), 'b01);
    step();
    chk("R7 irq lasts one cycle", int'(ch_irq), 0);
    xfer_done[0] = 1; step();
    chk("R7 stray done ignored", int'(ch_irq), 0);
    wbyte(1, 8'h80); wbyte(1, 8'h81);
    sw_trig[1] = 1; step();
    chk("R10 sw trigger on ch1 only", int'(req_valid), 'b10);
    rchk("R10 ch0 unchanged", 0, 'h80);
    req_ready[1] = 1; step();
    xfer_done[1] = 1; step();
    chk("R10 irq on ch1 only", int'(ch_irq), 'b10);
    rchk("R7 ch1 start cleared", 1, 'h80);
  endtask

  task automatic t_abort();
    to_busy(0);
    wbyte(0, 8'h80);
    chk("R8 abort pulse while running", int'(xfer_abort), 'b01);
    chk("R8 no irq on abort", int'(ch_irq), 0);
    rchk("R8 start cleared by abort", 0, 'h80);
    step();
    chk("R8 abort lasts one cycle", int'(xfer_abort), 0);
    xfer_done[0] = 1; step();
    chk("R8 late done ignored", int'(ch_irq), 0);
    wbyte(0, 8'h81);
    sw_trig[0] = 1; step();
    chk("R8 pending request", int'(req_valid), 'b01);
    wbit(0, 0, 1'b0);
    chk("R8 abort while requesting", int'(xfer_abort), 'b01);
    chk("R8 request withdrawn", int'(req_valid), 0);
    step();
  endtask

  task automatic t_collision();
    to_busy(0);
    xfer_done[0] = 1; wr_en = 1; wr_addr = 0; wr_data = 8'h81; step();
    rchk("R9 done beats start write", 0, 'h80);
    chk("R9 irq fires", int'(ch_irq), 'b01);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_readback();
    t_protect();
    t_bitwrite();
    t_transfer();
    t_abort();
    t_collision();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule